// File: doc/BRIEF.md
# Circular Store Queue with In-Order Writeback

This block holds the stores of one thread between dispatch and the moment their write to memory has completed. Stores are placed at the tail of a circular buffer in program order, each tagged with an age (sequence number). Address, size and data arrive later through an execute-write port. A commit request carrying a sequence bound marks every older store as committed and ready to write back. A writeback pointer then drains committed stores to memory strictly in order through a valid/ready request channel. An entry is released at the head only after the memory side acknowledges that its write has completed.

A refused write request puts the queue into a blocked state. No further request is made until a retry pulse arrives, and then the same entry is offered again. A squash request removes every uncommitted store younger than a given sequence number by pulling the tail back. One slot of the ring is always left unused as a sentinel, so the queue reports full at one entry short of its physical depth. The occupied count, the number of stores still waiting to be issued and the full flag are outputs.

Top module: `sq_store_queue`

## Requirements
- R1: After reset the queue is empty: `store_count` is 0, `wb_pending` is 0, `sq_full` is 0, `wb_blocked` is 0, `wb_req_valid` is 0 and `alloc_idx` is 0.
- R2: When accepted, an allocation writes its sequence number into the slot `alloc_idx` at the clock edge. After that edge `alloc_idx` has advanced by one modulo DEPTH and `store_count` is one higher.
- R3: `sq_full` is 1 exactly when `store_count` is at least DEPTH-1. An allocation attempted while full is ignored, so the count and the tail stay unchanged.
- R4: An execute-write to an occupied slot records its address, size and data. A later writeback request for that slot presents those values.
- R5: A commit with bound C marks every occupied, uncommitted store whose sequence S is older than C, meaning that bit 15 of (S - C) mod 2^16 is 1. `wb_pending` rises by the number of stores newly marked.
- R6: `wb_req_valid` is 1 only when the slot at the writeback pointer is occupied, committed and not completed, and the queue is not blocked. Requests are made in allocation order, and the pointer moves on by one per accepted request.
- R7: A request that is refused (`wb_req_valid` high and `wb_req_ready` low) sets `wb_blocked` and stops requests until a `mem_retry` pulse. The same slot is then requested again. `wb_pending` falls by one only when a request is accepted.
- R8: A slot is freed only when it is at the head and its write has been acknowledged. `store_count` falls one cycle after the acknowledge edge. Committing or issuing a store never frees it.
- R9: A squash with bound Q removes every occupied, uncommitted store whose sequence is younger than Q, so the tail moves back by that number of slots. An allocation presented in the same cycle as a squash is ignored.
- R10: Age comparisons wrap, so stores whose sequence numbers cross from 16'hFFFF to 16'h0000 are committed in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | 16 | Sequence number of the new store |
| alloc_idx | output | PTR_W | Slot the next allocation uses (tail) |
| exec_valid | input | 1 | Execute-write strobe |
| exec_idx | input | PTR_W | Slot being written |
| exec_addr | input | ADDR_W | Store byte address |
| exec_size | input | SIZE_W | Store size in bytes |
| exec_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | 16 | Commit bound; older stores commit |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | 16 | Squash bound; younger uncommitted stores are removed |
| wb_req_valid | output | 1 | Write request to memory |
| wb_req_ready | input | 1 | Memory accepts the request |
| wb_req_idx | output | PTR_W | Slot of the request, used for the acknowledge |
| wb_req_addr | output | ADDR_W | Request address |
| wb_req_size | output | SIZE_W | Request size |
| wb_req_data | output | DATA_W | Request data |
| mem_retry | input | 1 | Memory can take a refused request again |
| wb_ack_valid | input | 1 | Write completion |
| wb_ack_idx | input | PTR_W | Slot whose write completed |
| sq_full | output | 1 | Occupancy reached DEPTH-1 |
| store_count | output | CNT_W | Occupied slots |
| wb_pending | output | CNT_W | Committed stores not yet issued |
| wb_blocked | output | 1 | A request was refused and awaits retry |

## Verification
The queue is first filled with sequence numbers that cross the 16-bit wrap and then committed in two steps. This distinguishes a wrap-safe age compare from a plain magnitude compare, which would commit nothing in the second step. Directed steps follow a refusal, a retry, one accepted request, an acknowledge, and a squash combined with an allocation. These separate acceptance from issue, issue from freeing, and squash priority over allocation. A long seeded random run then mixes allocations, execute-writes, commits at random bounds, occasional squashes, refusals, retries and in-order acknowledges. Every cycle is compared against a bench model, so pointer wrap at every position and collisions such as a commit and a squash in the same cycle are exercised.

// File: rtl/sq_pkg.sv
package sq_pkg;
  parameter int SEQ_W = 16;
  typedef logic [SEQ_W-1:0] seq_t;

  // a is older than b when a - b is negative in wrap-around arithmetic
  function automatic logic seq_older(seq_t a, seq_t b);
    seq_t d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  // index p moved by n slots (n may be negative, |n| <= depth)
  function automatic int ring_add(int p, int n, int depth);
    return (p + n + depth) % depth;
  endfunction

  // distance from base to idx going forward around the ring
  function automatic int ring_off(int idx, int base, int depth);
    return (idx - base + depth) % depth;
  endfunction
endpackage

// File: rtl/sq_entry.sv
module sq_entry
  import sq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  seq_t              alloc_seq,
  input  logic              exec_en,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [SIZE_W-1:0] exec_size,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              commit_en,
  input  logic              ack_en,
  output seq_t              e_seq,
  output logic [ADDR_W-1:0] e_addr,
  output logic [SIZE_W-1:0] e_size,
  output logic [DATA_W-1:0] e_data,
  output logic              e_can_wb,
  output logic              e_committed,
  output logic              e_completed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_seq       <= '0;
      e_addr      <= '0;
      e_size      <= '0;
      e_data      <= '0;
      e_can_wb    <= 1'b0;
      e_committed <= 1'b0;
      e_completed <= 1'b0;
    end else if (alloc_en) begin
      e_seq       <= alloc_seq;
      e_addr      <= '0;
      e_size      <= '0;
      e_data      <= '0;
      e_can_wb    <= 1'b0;
      e_committed <= 1'b0;
      e_completed <= 1'b0;
    end else begin
      if (exec_en) begin
        e_addr <= exec_addr;
        e_size <= exec_size;
        e_data <= exec_data;
      end
      if (commit_en) begin
        e_committed <= 1'b1;
        e_can_wb    <= 1'b1;
      end
      if (ack_en) e_completed <= 1'b1;
    end
  end
endmodule

// File: rtl/sq_ring_ptrs.sv
module sq_ring_ptrs
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             free_fire,
  input  logic             issue_fire,
  input  logic [CNT_W-1:0] kill_cnt,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] wb_ptr,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count
);
  int tail_step;
  always_comb tail_step = int'(alloc_fire) - int'(kill_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      wb_ptr <= '0;
      tail   <= '0;
      count  <= '0;
    end else begin
      if (free_fire)  head   <= PTR_W'(ring_add(int'(head), 1, DEPTH));
      if (issue_fire) wb_ptr <= PTR_W'(ring_add(int'(wb_ptr), 1, DEPTH));
      tail  <= PTR_W'(ring_add(int'(tail), tail_step, DEPTH));
      count <= CNT_W'(int'(count) + tail_step - int'(free_fire));
    end
  end
endmodule

// File: rtl/sq_wb_ctrl.sv
module sq_wb_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cand,
  input  logic req_ready,
  input  logic retry,
  output logic req_valid,
  output logic issue,
  output logic blocked
);
  always_comb begin
    req_valid = cand && !blocked;
    issue     = req_valid && req_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       blocked <= 1'b0;
    else if (req_valid && !req_ready) blocked <= 1'b1;
    else if (retry)                   blocked <= 1'b0;
  end
endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [15:0]       alloc_seq,
  output logic [PTR_W-1:0]  alloc_idx,
  input  logic              exec_valid,
  input  logic [PTR_W-1:0]  exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [SIZE_W-1:0] exec_size,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              commit_valid,
  input  logic [15:0]       commit_seq,
  input  logic              squash_valid,
  input  logic [15:0]       squash_seq,
  output logic              wb_req_valid,
  input  logic              wb_req_ready,
  output logic [PTR_W-1:0]  wb_req_idx,
  output logic [ADDR_W-1:0] wb_req_addr,
  output logic [SIZE_W-1:0] wb_req_size,
  output logic [DATA_W-1:0] wb_req_data,
  input  logic              mem_retry,
  input  logic              wb_ack_valid,
  input  logic [PTR_W-1:0]  wb_ack_idx,
  output logic              sq_full,
  output logic [CNT_W-1:0]  store_count,
  output logic [CNT_W-1:0]  wb_pending,
  output logic              wb_blocked
);
  // ring state
  logic [PTR_W-1:0] head, wb_ptr, tail;
  logic [CNT_W-1:0] count;

  // per-entry state
  seq_t              e_seq       [DEPTH];
  logic [ADDR_W-1:0] e_addr      [DEPTH];
  logic [SIZE_W-1:0] e_size      [DATA_W > 0 ? DEPTH : 1];
  logic [DATA_W-1:0] e_data      [DEPTH];
  logic [DEPTH-1:0]  e_can_wb, e_committed, e_completed;

  // per-entry controls
  logic [DEPTH-1:0] in_q, kill, commit_en, ack_en, exec_en, alloc_en;

  // named events
  logic             alloc_fire, free_fire, issue_fire, wb_cand;
  logic [CNT_W-1:0] kill_cnt, commit_cnt;
  int               wb_off;

  always_comb begin
    wb_off = ring_off(int'(wb_ptr), int'(head), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      int off;
      off          = ring_off(i, int'(head), DEPTH);
      in_q[i]      = off < int'(count);
      kill[i]      = squash_valid && in_q[i] && !e_committed[i] &&
                     seq_older(seq_t'(squash_seq), e_seq[i]);
      commit_en[i] = commit_valid && in_q[i] && !e_committed[i] && !kill[i] &&
                     seq_older(e_seq[i], seq_t'(commit_seq));
      ack_en[i]    = wb_ack_valid && (wb_ack_idx == PTR_W'(i)) && in_q[i] &&
                     (off < wb_off) && !e_completed[i];
      exec_en[i]   = exec_valid && (exec_idx == PTR_W'(i)) && in_q[i];
    end
    kill_cnt   = CNT_W'($countones(kill));
    commit_cnt = CNT_W'($countones(commit_en));
    sq_full    = count >= CNT_W'(DEPTH - 1);
    alloc_fire = alloc_valid && !sq_full && !squash_valid;
    for (int i = 0; i < DEPTH; i++)
      alloc_en[i] = alloc_fire && (tail == PTR_W'(i));
    free_fire  = (count != '0) && e_completed[head];
    wb_cand    = (wb_off < int'(count)) && e_can_wb[wb_ptr] && !e_completed[wb_ptr];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    sq_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_en    (alloc_en[g]),
      .alloc_seq   (seq_t'(alloc_seq)),
      .exec_en     (exec_en[g]),
      .exec_addr   (exec_addr),
      .exec_size   (exec_size),
      .exec_data   (exec_data),
      .commit_en   (commit_en[g]),
      .ack_en      (ack_en[g]),
      .e_seq       (e_seq[g]),
      .e_addr      (e_addr[g]),
      .e_size      (e_size[g]),
      .e_data      (e_data[g]),
      .e_can_wb    (e_can_wb[g]),
      .e_committed (e_committed[g]),
      .e_completed (e_completed[g])
    );
  end

  sq_ring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .free_fire  (free_fire),
    .issue_fire (issue_fire),
    .kill_cnt   (kill_cnt),
    .head       (head),
    .wb_ptr     (wb_ptr),
    .tail       (tail),
    .count      (count)
  );

  sq_wb_ctrl u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand      (wb_cand),
    .req_ready (wb_req_ready),
    .retry     (mem_retry),
    .req_valid (wb_req_valid),
    .issue     (issue_fire),
    .blocked   (wb_blocked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wb_pending <= '0;
    else        wb_pending <= wb_pending + commit_cnt - CNT_W'(issue_fire);
  end

  always_comb begin
    alloc_idx   = tail;
    store_count = count;
    wb_req_idx  = wb_ptr;
    wb_req_addr = e_addr[wb_ptr];
    wb_req_size = e_size[wb_ptr];
    wb_req_data = e_data[wb_ptr];
  end
endmodule

// File: rtl/sq_store_queue_chk.sv
module sq_store_queue_chk #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             commit_valid,
  input logic             sq_full,
  input logic [CNT_W-1:0] store_count,
  input logic [CNT_W-1:0] wb_pending,
  input logic             wb_req_valid,
  input logic             wb_req_ready,
  input logic [PTR_W-1:0] wb_req_idx,
  input logic             wb_blocked,
  input logic             issue_fire,
  input logic             free_fire
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    store_count <= CNT_W'(DEPTH - 1));

  p_full_no_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && sq_full) |=> store_count <= $past(store_count));

  p_blocked_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_blocked |-> !wb_req_valid);

  p_refuse_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_valid && !wb_req_ready) |=> (wb_blocked && wb_req_idx == $past(wb_req_idx)));

  p_issue_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && !commit_valid) |=> wb_pending == $past(wb_pending) - CNT_W'(1));

  p_pending_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pending <= store_count);

  p_free_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_fire |-> store_count != '0);
endmodule

bind sq_store_queue sq_store_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .commit_valid (commit_valid),
  .sq_full      (sq_full),
  .store_count  (store_count),
  .wb_pending   (wb_pending),
  .wb_req_valid (wb_req_valid),
  .wb_req_ready (wb_req_ready),
  .wb_req_idx   (wb_req_idx),
  .wb_blocked   (wb_blocked),
  .issue_fire   (issue_fire),
  .free_fire    (free_fire)
);

// File: tb/sq_store_queue_tb_top.sv
`timescale 1ns/1ps
module sq_store_queue_tb_top;
  localparam int D = 8;
  localparam int PW = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0; logic [15:0] alloc_seq = 0; logic [PW-1:0] alloc_idx;
  logic exec_valid = 0; logic [PW-1:0] exec_idx = 0;
  logic [31:0] exec_addr = 0; logic [3:0] exec_size = 0; logic [63:0] exec_data = 0;
  logic commit_valid = 0; logic [15:0] commit_seq = 0;
  logic squash_valid = 0; logic [15:0] squash_seq = 0;
  logic wb_req_valid; logic wb_req_ready = 0; logic [PW-1:0] wb_req_idx;
  logic [31:0] wb_req_addr; logic [3:0] wb_req_size; logic [63:0] wb_req_data;
  logic mem_retry = 0; logic wb_ack_valid = 0; logic [PW-1:0] wb_ack_idx = 0;
  logic sq_full, wb_blocked; logic [CW-1:0] store_count, wb_pending;

  always #2.5 clk = ~clk;

  sq_store_queue dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model state
  int m_head, m_wb, m_tail, m_cnt, m_pend;
  bit m_blk, m_alloc_done;
  logic [15:0] m_seq [D];
  logic [31:0] m_addr [D];
  logic [3:0]  m_size [D];
  logic [63:0] m_data [D];
  bit m_com [D], m_cmp [D];

  function automatic int off(int i); return (i - m_head + D) % D; endfunction
  function automatic bit older(logic [15:0] a, logic [15:0] b);
    logic [15:0] d; d = a - b; return d[15];
  endfunction
  function automatic bit exp_req();
    return off(m_wb) < m_cnt && m_com[m_wb] && !m_cmp[m_wb] && !m_blk;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_head = 0; m_wb = 0; m_tail = 0; m_cnt = 0; m_pend = 0; m_blk = 0;
    for (int i = 0; i < D; i++) begin
      m_seq[i] = 0; m_addr[i] = 0; m_size[i] = 0; m_data[i] = 0;
      m_com[i] = 0; m_cmp[i] = 0;
    end
  endtask

  task automatic model_step();
    bit ev, iss, fr, al; int kc, woff; bit kl [D]; bit cm [D];
    ev = exp_req(); woff = off(m_wb); kc = 0;
    for (int i = 0; i < D; i++) begin
      bit v; v = off(i) < m_cnt;
      kl[i] = squash_valid && v && !m_com[i] && older(squash_seq, m_seq[i]);
      cm[i] = commit_valid && v && !m_com[i] && !kl[i] && older(m_seq[i], commit_seq);
      if (kl[i]) kc++;
    end
    iss = ev && wb_req_ready;
    fr  = m_cnt > 0 && m_cmp[m_head];
    al  = alloc_valid && m_cnt < D - 1 && !squash_valid;
    if (wb_ack_valid && off(int'(wb_ack_idx)) < m_cnt && off(int'(wb_ack_idx)) < woff)
      m_cmp[wb_ack_idx] = 1;
    if (exec_valid && off(int'(exec_idx)) < m_cnt) begin
      m_addr[exec_idx] = exec_addr; m_size[exec_idx] = exec_size; m_data[exec_idx] = exec_data;
    end
    for (int i = 0; i < D; i++) if (cm[i]) begin m_com[i] = 1; m_pend++; end
    if (iss) m_pend--;
    if (ev && !wb_req_ready) m_blk = 1; else if (mem_retry) m_blk = 0;
    if (al) begin
      m_seq[m_tail] = alloc_seq; m_addr[m_tail] = 0; m_size[m_tail] = 0;
      m_data[m_tail] = 0; m_com[m_tail] = 0; m_cmp[m_tail] = 0;
    end
    m_alloc_done = al;
    if (fr) m_head = (m_head + 1) % D;
    if (iss) m_wb = (m_wb + 1) % D;
    m_tail = (m_tail + int'(al) - kc + D) % D;
    m_cnt = m_cnt + int'(al) - int'(fr) - kc;
  endtask

  task automatic compare_all();
    bit ev; ev = exp_req();
    chk(store_count == CW'(m_cnt), "R2 store_count", store_count, m_cnt);
    chk(sq_full == (m_cnt >= D - 1), "R3 sq_full", sq_full, m_cnt >= D - 1);
    chk(alloc_idx == PW'(m_tail), "R9 alloc_idx", alloc_idx, m_tail);
    chk(wb_pending == CW'(m_pend), "R5 wb_pending", wb_pending, m_pend);
    chk(wb_blocked == m_blk, "R7 wb_blocked", wb_blocked, m_blk);
    chk(wb_req_valid == ev, "R6 wb_req_valid", wb_req_valid, ev);
    if (ev) begin
      chk(wb_req_idx == PW'(m_wb), "R6 wb_req_idx", wb_req_idx, m_wb);
      chk(wb_req_addr == m_addr[m_wb] && wb_req_size == m_size[m_wb] &&
          wb_req_data == m_data[m_wb], "R4 wb_req_data", wb_req_data, m_data[m_wb]);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    #1;
    compare_all();
    @(negedge clk);
    alloc_valid = 0; exec_valid = 0; commit_valid = 0; squash_valid = 0;
    mem_retry = 0; wb_ack_valid = 0;
  endtask

  logic [15:0] next_seq;

  initial begin
    void'($urandom(32'h5EED));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(store_count == 0 && wb_pending == 0 && !sq_full && !wb_blocked &&
        !wb_req_valid && alloc_idx == 0, "R1 reset", store_count, 0);

    // R2/R3/R10: fill across the sequence wrap
    next_seq = 16'hFFFC;
    for (int k = 0; k < D; k++) begin
      alloc_valid = 1; alloc_seq = next_seq;
      cycle();
      if (m_alloc_done) next_seq++;
    end
    chk(store_count == CW'(D - 1) && sq_full, "R3 full after fill", store_count, D - 1);
    chk(alloc_idx == PW'(D - 1), "R3 ignored alloc keeps tail", alloc_idx, D - 1);

    // R4 execute-writes
    for (int k = 0; k < D - 1; k++) begin
      exec_valid = 1; exec_idx = PW'(k); exec_addr = 32'h1000 + 32'(k * 8);
      exec_size = 4'd8; exec_data = 64'hA5A5_0000_0000_0000 | 64'(k);
      cycle();
    end

    // R5/R10: two commits, second across the wrap, memory refusing
    wb_req_ready = 0;
    commit_valid = 1; commit_seq = 16'hFFFF;
    cycle();
    chk(wb_pending == 3, "R5 first commit pending", wb_pending, 3);
    chk(wb_req_valid && wb_req_idx == 0 && wb_req_addr == 32'h1000, "R4 first request", wb_req_addr, 32'h1000);
    commit_valid = 1; commit_seq = 16'h0002;
    cycle();
    chk(wb_pending == 6, "R10 wrap commit pending", wb_pending, 6);
    chk(wb_blocked && !wb_req_valid, "R7 blocked after refusal", wb_blocked, 1);
    cycle();
    chk(wb_pending == 6 && wb_blocked, "R7 still blocked without retry", wb_pending, 6);

    // R7 retry, then one acceptance
    mem_retry = 1;
    cycle();
    chk(wb_req_valid && wb_req_idx == 0, "R7 same slot after retry", wb_req_idx, 0);
    wb_req_ready = 1;
    cycle();
    wb_req_ready = 0;
    chk(wb_req_idx == 1 && wb_pending == 5, "R6 pointer advanced", wb_req_idx, 1);
    chk(store_count == CW'(D - 1), "R8 issue does not free", store_count, D - 1);
    // refused again: unblock before continuing
    cycle();
    mem_retry = 1;
    cycle();

    // R8 acknowledge slot 0
    wb_ack_valid = 1; wb_ack_idx = 0;
    cycle();
    chk(store_count == CW'(D - 1), "R8 count held on ack edge", store_count, D - 1);
    cycle();
    chk(store_count == CW'(D - 2), "R8 freed after ack", store_count, D - 2);

    // R9 squash younger than seq 0x0001 with a simultaneous allocation
    squash_valid = 1; squash_seq = 16'h0001; alloc_valid = 1; alloc_seq = next_seq;
    cycle();
    chk(store_count == CW'(D - 3) && alloc_idx == 6, "R9 squash pulled tail back", alloc_idx, 6);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int woff;
      alloc_valid = ($urandom % 3) == 0; alloc_seq = next_seq;
      if (m_cnt > 0 && ($urandom % 2) == 0) begin
        int o; o = $urandom % m_cnt;
        exec_valid = 1; exec_idx = PW'((m_head + o) % D);
        exec_addr = $urandom; exec_size = 4'($urandom); exec_data = {$urandom, $urandom};
      end
      if (m_cnt > 0 && ($urandom % 6) == 0) begin
        commit_valid = 1; commit_seq = m_seq[(m_head + ($urandom % m_cnt)) % D] + 16'd1;
      end
      if (m_cnt > 0 && ($urandom % 40) == 0) begin
        squash_valid = 1; squash_seq = m_seq[(m_head + ($urandom % m_cnt)) % D];
      end
      wb_req_ready = ($urandom % 4) != 0;
      mem_retry = m_blk && ($urandom % 3) == 0;
      woff = off(m_wb);
      for (int o = 0; o < woff; o++) begin
        int ix; ix = (m_head + o) % D;
        if (!m_cmp[ix]) begin
          wb_ack_valid = ($urandom % 2) == 0; wb_ack_idx = PW'(ix);
          break;
        end
      end
      cycle();
      if (m_alloc_done) next_seq++;
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule